// File: doc/BRIEF.md
# Memory Access Fault Checker

This block inspects every data load, data store and instruction-side bus response of a 32-bit processor and decides, within one clock, whether a hardware exception is to be taken. It looks for three kinds of fault. The first is an access whose address is not a multiple of its size. The second is a stack-checked access that falls outside a window bounded by a low and a high limit. The third is an error returned by the instruction or data bus.

When a fault wins, the block captures the offending address and a packed status word into registers. It also raises a request towards the exception sequencer for one cycle. The status word carries a cause code. For a misaligned access it also carries the access direction, whether the access was a word, and the destination register number, so that a handler can finish or emulate the access.

Only the misalignment and bus-error paths depend on the global exception enable. A stack violation is always reported. Bus errors are further gated by one configuration enable for the instruction side and one for the data side.

Top module: `mem_fault_chk`

## Requirements
- R1: An access with `acc_valid` high is misaligned when `acc_addr & acc_size_mask` is nonzero. The mask encoding is 2'b11 for a word, 2'b01 for a halfword and 2'b00 for a byte, so a byte access is never misaligned.
- R2: For a misaligned access the status word has cause 1 in bits 4:0, `acc_rd` in bits 9:5, `acc_write` in bit 10, bit 11 set only when the mask is 2'b11, and every other bit zero.
- R3: A misaligned access raises a request only while `exc_enable` is 1. With `exc_enable` at 0 it changes neither output register and raises no request.
- R4: With `stk_check` and `acc_valid` high, an address strictly below `stk_low` or strictly above `stk_high` raises a request with cause 7 in bits 4:0 and zeros elsewhere. This happens whatever `exc_enable` holds. Addresses equal to either limit are legal.
- R5: A `bus_err` pulse is ignored while `exc_enable` is 0. Otherwise, with `bus_fetch` high it raises cause 2 if `ibus_exc_cfg` is set, and with `bus_fetch` low it raises cause 3 if `dbus_exc_cfg` is set. All other status bits are zero. The bus error uses `acc_addr` and does not depend on `acc_valid`.
- R6: When several faults request in the same cycle, the bus error wins over misalignment, and misalignment wins over a stack violation.
- R7: On a request, `exc_addr` takes the access address and `exc_status` takes the winner's status word. Both registers hold their value in any cycle with no request.
- R8: All outputs are registered: a fault presented in one cycle shows on the outputs after the next rising edge, and `exc_req` is high for exactly that one cycle per faulting cycle. A synchronous active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A load or store is presented this cycle |
| acc_addr | input | 32 | Access address, also used for bus errors |
| acc_size_mask | input | 2 | Alignment mask: 11 word, 01 halfword, 00 byte |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_rd | input | 5 | Destination or source register number |
| stk_check | input | 1 | Apply the stack window to this access |
| stk_low | input | 32 | Lowest legal stack address |
| stk_high | input | 32 | Highest legal stack address |
| bus_err | input | 1 | Bus error pulse |
| bus_fetch | input | 1 | 1 if the bus error came from an instruction fetch |
| exc_enable | input | 1 | Global hardware exception enable |
| ibus_exc_cfg | input | 1 | Instruction-bus errors may raise exceptions |
| dbus_exc_cfg | input | 1 | Data-bus errors may raise exceptions |
| exc_addr | output | 32 | Captured faulting address |
| exc_status | output | 32 | Captured exception status word |
| exc_req | output | 1 | One-cycle exception request |

## Verification
The bench goes after the stack window edges. It places the address exactly at, and one step outside, each limit; a design with an off-by-one comparison would fault on a legal address or let an illegal one pass. It drives misaligned accesses with exceptions disabled while stack faults are pending. A design that gated the stack check with the global enable would then stay silent, and one that let the disabled misalignment still win the priority would report cause 1. It stacks all three faults in one cycle and sweeps the bus-error enables across both sides. A wrong priority or a swapped side shows up as a wrong cause code, and a word/halfword mix-up shows up as a wrong bit 11.

// File: rtl/mfc_pkg.sv
// Package: shared constants for the memory access fault checker.
// Assumes the status word is at least 12 bits wide.
package mfc_pkg;
    localparam int CAUSE_W  = 5;
    localparam int RD_LSB   = 5;
    localparam int WR_BIT   = 10;
    localparam int WORD_BIT = 11;

    localparam logic [CAUSE_W-1:0] CAUSE_UNALIGN = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_IBUS    = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_DBUS    = 5'd3;
    localparam logic [CAUSE_W-1:0] CAUSE_STACK   = 5'd7;
endpackage

// File: rtl/mfc_align_check.sv
// Module: alignment detector. Flags an access whose address has a set bit
// under the size mask, and reports whether the mask denotes a full word.
// Assumes the mask is a run of ones from bit 0 (00, 01 or 11).
module mfc_align_check #(
    parameter int MASK_W = 2,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] size_mask,
    output logic              misaligned,
    output logic              is_word
);
    logic [MASK_W-1:0] bit_hit;

    // per-bit overlap of address and mask
    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        assign bit_hit[i] = addr[i] & size_mask[i];
    end

    // combine overlaps into the fault flag and decode the word size
    always_comb begin
        misaligned = |bit_hit;
        is_word    = &size_mask;
    end
endmodule

// File: rtl/mfc_stack_check.sv
// Module: stack window comparator. Flags an enabled access that lies
// strictly outside [low, high]. Both limits are legal addresses.
module mfc_stack_check #(
    parameter int ADDR_W = 32
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] low,
    input  logic [ADDR_W-1:0] high,
    output logic              violation
);
    logic below, above;

    // unsigned compare against each limit
    always_comb begin
        below     = addr < low;
        above     = addr > high;
        violation = enable & (below | above);
    end
endmodule

// File: rtl/mfc_fault_select.sv
// Module: priority selector and status packer. Takes the already gated
// request of each source and builds the status word of the winner.
// Priority: bus error, then misalignment, then stack protection.
module mfc_fault_select
    import mfc_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int REG_W  = 5
) (
    input  logic              bus_raise,
    input  logic              bus_fetch,
    input  logic              mis_raise,
    input  logic              mis_word,
    input  logic              mis_write,
    input  logic [REG_W-1:0]  mis_rd,
    input  logic              stk_raise,
    output logic              req,
    output logic [STAT_W-1:0] status
);
    // pick the winning source and pack its status word
    always_comb begin
        req    = bus_raise | mis_raise | stk_raise;
        status = '0;
        if (bus_raise) begin
            status[CAUSE_W-1:0] = bus_fetch ? CAUSE_IBUS : CAUSE_DBUS;
        end else if (mis_raise) begin
            status[CAUSE_W-1:0]           = CAUSE_UNALIGN;
            status[RD_LSB +: REG_W]       = mis_rd;
            status[WR_BIT]                = mis_write;
            status[WORD_BIT]              = mis_word;
        end else if (stk_raise) begin
            status[CAUSE_W-1:0] = CAUSE_STACK;
        end
    end
endmodule

// File: rtl/mem_fault_chk.sv
// Module: memory access fault checker top. Gates each fault source with
// its enables, selects a winner and registers address, status and request.
// Assumes inputs are synchronous to clk; reset is synchronous, active low.
module mem_fault_chk
    import mfc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 2,
    parameter int REG_W  = 5,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MASK_W-1:0] acc_size_mask,
    input  logic              acc_write,
    input  logic [REG_W-1:0]  acc_rd,
    input  logic              stk_check,
    input  logic [ADDR_W-1:0] stk_low,
    input  logic [ADDR_W-1:0] stk_high,
    input  logic              bus_err,
    input  logic              bus_fetch,
    input  logic              exc_enable,
    input  logic              ibus_exc_cfg,
    input  logic              dbus_exc_cfg,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [STAT_W-1:0] exc_status,
    output logic              exc_req
);
    logic              mis_hit, mis_word, stk_hit;
    logic              bus_raise, mis_raise, stk_raise;
    logic              req_next;
    logic [STAT_W-1:0] status_next;

    mfc_align_check #(.MASK_W(MASK_W), .ADDR_W(ADDR_W)) u_align (
        .addr(acc_addr), .size_mask(acc_size_mask),
        .misaligned(mis_hit), .is_word(mis_word)
    );

    mfc_stack_check #(.ADDR_W(ADDR_W)) u_stack (
        .enable(stk_check), .addr(acc_addr), .low(stk_low), .high(stk_high),
        .violation(stk_hit)
    );

    // apply the enables that govern each source
    always_comb begin
        bus_raise = bus_err & exc_enable & (bus_fetch ? ibus_exc_cfg : dbus_exc_cfg);
        mis_raise = acc_valid & mis_hit & exc_enable;
        stk_raise = acc_valid & stk_hit;
    end

    mfc_fault_select #(.STAT_W(STAT_W), .REG_W(REG_W)) u_sel (
        .bus_raise(bus_raise), .bus_fetch(bus_fetch),
        .mis_raise(mis_raise), .mis_word(mis_word), .mis_write(acc_write),
        .mis_rd(acc_rd), .stk_raise(stk_raise),
        .req(req_next), .status(status_next)
    );

    // capture the exception record only when a request is made
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_addr   <= '0;
            exc_status <= '0;
            exc_req    <= 1'b0;
        end else begin
            exc_req <= req_next;
            if (req_next) begin
                exc_addr   <= acc_addr;
                exc_status <= status_next;
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_next |=> ($stable(exc_addr) && $stable(exc_status))) else $error("hold"); // R7
    AST_STACK_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && stk_check && (acc_addr < stk_low || acc_addr > stk_high))
        |=> exc_req) else $error("stack"); // R4
    AST_BUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !exc_enable) |=> !exc_req) else $error("bus mask"); // R5
    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (exc_status[4:0] inside {5'd1, 5'd2, 5'd3, 5'd7})) else $error("cause"); // R8
    AST_EXTRA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_status[4:0] != 5'd1) |-> (exc_status[11:5] == 7'd0)) else $error("pack"); // R2
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        exc_status[STAT_W-1:12] == '0) else $error("upper"); // R2
endmodule

// File: tb/sim_mem_fault_chk.sv
module sim_mem_fault_chk;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write, stk_check, bus_err, bus_fetch;
    logic        exc_enable, ibus_exc_cfg, dbus_exc_cfg;
    logic [31:0] acc_addr, stk_low, stk_high;
    logic [1:0]  acc_size_mask;
    logic [4:0]  acc_rd;
    logic [31:0] exc_addr, exc_status;
    logic        exc_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_addr = '0, m_stat = '0;
    logic        m_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_fault_chk u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size_mask(acc_size_mask), .acc_write(acc_write), .acc_rd(acc_rd),
        .stk_check(stk_check), .stk_low(stk_low), .stk_high(stk_high),
        .bus_err(bus_err), .bus_fetch(bus_fetch), .exc_enable(exc_enable),
        .ibus_exc_cfg(ibus_exc_cfg), .dbus_exc_cfg(dbus_exc_cfg),
        .exc_addr(exc_addr), .exc_status(exc_status), .exc_req(exc_req)
    );

    // reference: status word the requirements predict (bit 32 = request)
    function automatic logic [32:0] predict();
        logic b, m, s;
        b = bus_err && exc_enable && (bus_fetch ? ibus_exc_cfg : dbus_exc_cfg);
        m = acc_valid && exc_enable && ((acc_addr[1:0] & acc_size_mask) != 2'b00);
        s = acc_valid && stk_check && (acc_addr < stk_low || acc_addr > stk_high);
        if (b) return {1'b1, 32'(bus_fetch ? 2 : 3)};
        if (m) return {1'b1, 20'd0, (acc_size_mask == 2'b11), acc_write, acc_rd, 5'd1};
        if (s) return {1'b1, 32'd7};
        return {1'b0, 32'd0};
    endfunction

    task automatic compare(input string tag);
        n_chk++;
        if (exc_req !== m_req || exc_addr !== m_addr || exc_status !== m_stat) begin
            n_bad++;
            $display("FAIL %s: got req=%0b addr=%h stat=%h, expected req=%0b addr=%h stat=%h",
                     tag, exc_req, exc_addr, exc_status, m_req, m_addr, m_stat);
        end
    endtask

    // inputs already set at a falling edge; advance one cycle and compare
    task automatic step(input string tag);
        logic [32:0] p;
        p = predict();
        m_req = p[32];
        if (p[32]) begin
            m_addr = acc_addr;
            m_stat = p[31:0];
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        acc_valid = 0; acc_write = 0; acc_rd = 0; acc_size_mask = 0;
        stk_check = 0; bus_err = 0; bus_fetch = 0;
    endtask

    task automatic acc(input logic [31:0] a, input logic [1:0] mk, input logic wr,
                       input logic [4:0] rd, input logic sc, input string tag);
        acc_valid = 1; acc_addr = a; acc_size_mask = mk; acc_write = wr;
        acc_rd = rd; stk_check = sc; bus_err = 0;
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; idle(); acc_addr = 32'hFFFF_FFFF;
        stk_low = 32'h40; stk_high = 32'hC0;
        exc_enable = 1; ibus_exc_cfg = 1; dbus_exc_cfg = 1;
        acc_valid = 1; acc_size_mask = 2'b11; bus_err = 1;
        repeat (3) @(negedge clk);
        compare("R8 reset");
        rst_n = 1; idle();
        step("R8 idle after reset");

        // R1: byte never misaligned, halfword/word rules
        acc(32'h0000_0083, 2'b00, 0, 5'd3, 0, "R1 byte odd");
        acc(32'h0000_0082, 2'b01, 0, 5'd3, 0, "R1 half even");
        acc(32'h0000_0082, 2'b11, 1, 5'd17, 0, "R1 R2 word misaligned store");
        idle(); step("R8 single cycle request / R7 hold");
        acc(32'h0000_0051, 2'b01, 0, 5'd31, 0, "R2 half misaligned load bit11 clear");
        // R3: disabled misalignment, with a stack fault underneath
        exc_enable = 0;
        acc(32'h0000_0091, 2'b11, 1, 5'd9, 0, "R3 misaligned disabled holds");
        acc(32'h0000_0021, 2'b11, 1, 5'd9, 1, "R3 R4 disabled misalign, stack wins");
        // R4: window edges
        exc_enable = 1;
        acc(32'h40, 2'b11, 0, 5'd1, 1, "R4 at low limit");
        acc(32'hC0, 2'b11, 0, 5'd1, 1, "R4 at high limit");
        acc(32'h3C, 2'b11, 0, 5'd1, 1, "R4 below low");
        acc(32'hC4, 2'b11, 0, 5'd1, 1, "R4 above high");
        acc(32'hC4, 2'b11, 0, 5'd1, 0, "R4 check off");
        // R5: bus errors across enables and sides
        for (int k = 0; k < 16; k++) begin
            idle(); acc_addr = 32'h1000 + k;
            bus_err = 1; bus_fetch = k[0]; exc_enable = k[1];
            ibus_exc_cfg = k[2]; dbus_exc_cfg = k[3];
            step("R5 bus error sweep");
        end
        exc_enable = 1; ibus_exc_cfg = 1; dbus_exc_cfg = 1;
        // R6: all three at once, then misalign plus stack
        acc_valid = 1; acc_addr = 32'h0000_0003; acc_size_mask = 2'b11;
        acc_write = 1; acc_rd = 5'd7; stk_check = 1; bus_err = 1; bus_fetch = 0;
        step("R6 bus beats all");
        bus_err = 0; step("R6 misalign beats stack");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            acc_valid     = ($urandom_range(0, 3) != 0);
            acc_addr      = $urandom_range(0, 255);
            acc_size_mask = ($urandom_range(0, 2) == 0) ? 2'b00 :
                            ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b11;
            acc_write     = $urandom_range(0, 1);
            acc_rd        = 5'($urandom);
            stk_check     = $urandom_range(0, 1);
            stk_low       = $urandom_range(32, 96);
            stk_high      = $urandom_range(160, 224);
            bus_err       = ($urandom_range(0, 7) == 0);
            bus_fetch     = $urandom_range(0, 1);
            exc_enable    = ($urandom_range(0, 3) != 0);
            ibus_exc_cfg  = $urandom_range(0, 1);
            dbus_exc_cfg  = $urandom_range(0, 1);
            step("R1 R2 R3 R4 R5 R6 R7 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule